// File: doc/BRIEF.md
# Free-Running Timer with Input Capture and Output Compare

This block is a free-running up-counter with one capture channel and one compare channel. A CPU reaches it through an 8-bit register port. A prescaler divides the system clock, and the counter advances by one on each divided tick. A selected edge on the capture pin, after synchronisation, copies the counter into a capture register. The compare register is loaded one byte at a time. On the tick where the counter equals it, a programmed level is driven onto the compare pin.

Software reads the capture value as two bytes, high byte first. Reading the high byte freezes the capture register until the low byte is read, so the two bytes always belong to the same capture. Each channel has a status flag. A flag is cleared by a two-step handshake: read the status register while the flag is set, then access the channel's low data byte. The interrupt output is raised while any enabled flag is set.

Top module: `ctr16_capcmp`

## Requirements
- R1: After reset the control and status registers read 0x00, the compare pin is 0 and the interrupt output is 0.
- R2: The counter starts at 0xFFFC and steps by one once every PRESCALE (default 4) clocks. It wraps from 0xFFFF to 0x0000. A capture requested in the cycle after the k-th clock edge since reset returns 0xFFFC + floor((k+2)/4).
- R3: The capture input passes through two synchronising flops. Control bit 1 selects the edge: 1 means rising, 0 means falling. Only the selected edge loads the capture register and sets status bit 7. Capture high byte is at 0x14 and low byte at 0x15.
- R4: A read of 0x14 blocks all capture updates and flag setting until 0x15 is read. The low byte then returns the value held before the block.
- R5: A read of 0x15 clears status bit 7 only if a status read (0x13) saw bit 7 set earlier. A low-byte read without that status read leaves the flag set.
- R6: The compare test runs only on a counter tick. On a match, control bit 0 is copied onto the compare pin and status bit 6 is set.
- R7: From reset, no compare match can occur until the compare low byte (0x17) is first written. A write of the compare high byte (0x16) blocks matches until 0x17 is written.
- R8: A write of 0x17 clears status bit 6 if a status read saw bit 6 set earlier.
- R9: The interrupt output equals (status bit 7 AND control bit 7) OR (status bit 6 AND control bit 6).
- R10: The control register is at 0x12 and the status register is at 0x13. Only control bits 7, 6, 1 and 0 and status bits 7 and 6 are stored. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; side effects apply at the end of the cycle |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| cap_in | input | 1 | Asynchronous capture input |
| cmp_pin | output | 1 | Compare output level |
| irq | output | 1 | Timer interrupt request |

## Verification
Read data is valid in the same cycle as the strobe. The monitor samples it one nanosecond after the falling edge of that cycle, before any clear or block takes effect. A capture pin change driven after the k-th edge is loaded at edge k+3 and holds the counter value seen after edge k+2. The bench counts edges since reset and derives every expected capture value from that count. A compare target T updates the pin and the flag at edge 4·(T+1−0xFFFC mod 2^16). The bench checks the pin one edge earlier (unchanged) and at that edge (changed), which shows that the match waits for the tick.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   // control register bit positions
   localparam int CTL_CAP_IE = 7;
   localparam int CTL_CMP_IE = 6;
   localparam int CTL_EDGE   = 1;
   localparam int CTL_OLVL   = 0;
   // status register bit positions
   localparam int STS_CAP    = 7;
   localparam int STS_CMP    = 6;

   typedef struct packed {
      logic cap_ie;
      logic cmp_ie;
      logic edge_rise;
      logic out_lvl;
   } ctl_t;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_STAT,
      SEL_CAPH,
      SEL_CAPL,
      SEL_CMPH,
      SEL_CMPL
   } reg_sel_e;

   function automatic logic [7:0] pack_ctl(input ctl_t c);
      logic [7:0] b;
      b = '0;
      b[CTL_CAP_IE] = c.cap_ie;
      b[CTL_CMP_IE] = c.cmp_ie;
      b[CTL_EDGE]   = c.edge_rise;
      b[CTL_OLVL]   = c.out_lvl;
      return b;
   endfunction
endpackage

// File: rtl/tcc_prescale.sv
module tcc_prescale #(
   parameter int                CNT_W    = 16,
   parameter int                PRESCALE = 4,
   parameter logic [CNT_W-1:0]  CNT_RST  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             tick,
   output logic [CNT_W-1:0] cnt
);
   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam int             PRE_W    = $clog2(PRESCALE);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre_q <= '0;
            else if (pre_q == PRE_LAST) pre_q <= '0;
            else                       pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= CNT_RST;
      else if (tick) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tcc_capture.sv
module tcc_capture #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_in,
   input  logic             edge_rise,
   input  logic [CNT_W-1:0] cnt,
   input  logic             stat_rd,
   input  logic             hi_rd,
   input  logic             lo_rd,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_flag,
   output logic             cap_lock
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   sync_out;
   logic                   edge_hit;
   logic                   take;
   logic                   arm_q;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= cap_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   assign sync_out = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_out;
   end

   assign edge_hit = edge_rise ? (sync_out & ~prev_q) : (~sync_out & prev_q);
   assign take     = edge_hit & ~cap_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cap_val <= '0;
      else if (take) cap_val <= cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cap_lock <= 1'b0;
      else if (lo_rd) cap_lock <= 1'b0;
      else if (hi_rd) cap_lock <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  arm_q <= 1'b0;
      else if (lo_rd)              arm_q <= 1'b0;
      else if (stat_rd && cap_flag) arm_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cap_flag <= 1'b0;
      else if (take)           cap_flag <= 1'b1;
      else if (lo_rd && arm_q) cap_flag <= 1'b0;
   end
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              stat_rd,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              out_lvl,
   output logic [CNT_W-1:0]  cmp_val,
   output logic              cmp_flag,
   output logic              cmp_pin
);
   logic inhibit_q;
   logic arm_q;
   logic match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_val <= '1;
      end else if (hi_wr) begin
         cmp_val[CNT_W-1:DATA_W] <= wdata;
      end else if (lo_wr) begin
         cmp_val[DATA_W-1:0] <= wdata;
      end
   end

   // disarmed from reset and between the high and low byte writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     inhibit_q <= 1'b1;
      else if (hi_wr) inhibit_q <= 1'b1;
      else if (lo_wr) inhibit_q <= 1'b0;
   end

   assign match = tick & ~inhibit_q & (cnt == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   arm_q <= 1'b0;
      else if (lo_wr)               arm_q <= 1'b0;
      else if (stat_rd && cmp_flag) arm_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cmp_flag <= 1'b0;
      else if (match)          cmp_flag <= 1'b1;
      else if (lo_wr && arm_q) cmp_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cmp_pin <= 1'b0;
      else if (match) cmp_pin <= out_lvl;
   end
endmodule

// File: rtl/ctr16_capcmp.sv
module ctr16_capcmp
   import tcc_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter int         CNT_W       = 16,
   parameter int         ADDR_W      = 8,
   parameter int         PRESCALE    = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0]  CNT_RST   = {{(CNT_W-2){1'b1}}, 2'b00},
   parameter logic [ADDR_W-1:0] OFS_CTRL  = 8'h12,
   parameter logic [ADDR_W-1:0] OFS_STAT  = 8'h13,
   parameter logic [ADDR_W-1:0] OFS_CAPH  = 8'h14,
   parameter logic [ADDR_W-1:0] OFS_CAPL  = 8'h15,
   parameter logic [ADDR_W-1:0] OFS_CMPH  = 8'h16,
   parameter logic [ADDR_W-1:0] OFS_CMPL  = 8'h17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cap_in,
   output logic              cmp_pin,
   output logic              irq
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("DATA_W must be 8 for the fixed control and status layout");
      end
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
         $error("CNT_W must be exactly two data bytes");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("PRESCALE must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   reg_sel_e          sel;
   logic              rd_stb, wr_stb;
   logic              stat_rd, caph_rd, capl_rd, cmph_wr, cmpl_wr, ctrl_wr;
   ctl_t              ctl_q;
   logic              tick;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cap_val;
   logic              cap_flag, cap_lock;
   logic [CNT_W-1:0]  cmp_val;
   logic              cmp_flag;
   logic              unused_wbits;

   always_comb begin
      if      (bus_addr == OFS_CTRL) sel = SEL_CTRL;
      else if (bus_addr == OFS_STAT) sel = SEL_STAT;
      else if (bus_addr == OFS_CAPH) sel = SEL_CAPH;
      else if (bus_addr == OFS_CAPL) sel = SEL_CAPL;
      else if (bus_addr == OFS_CMPH) sel = SEL_CMPH;
      else if (bus_addr == OFS_CMPL) sel = SEL_CMPL;
      else                           sel = SEL_NONE;
   end

   assign rd_stb  = bus_sel & bus_rd;
   assign wr_stb  = bus_sel & bus_wr;
   assign stat_rd = rd_stb & (sel == SEL_STAT);
   assign caph_rd = rd_stb & (sel == SEL_CAPH);
   assign capl_rd = rd_stb & (sel == SEL_CAPL);
   assign ctrl_wr = wr_stb & (sel == SEL_CTRL);
   assign cmph_wr = wr_stb & (sel == SEL_CMPH);
   assign cmpl_wr = wr_stb & (sel == SEL_CMPL);

   assign unused_wbits = ^bus_wdata[5:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctrl_wr) begin
         ctl_q.cap_ie    <= bus_wdata[CTL_CAP_IE];
         ctl_q.cmp_ie    <= bus_wdata[CTL_CMP_IE];
         ctl_q.edge_rise <= bus_wdata[CTL_EDGE];
         ctl_q.out_lvl   <= bus_wdata[CTL_OLVL];
      end
   end

   tcc_prescale #(
      .CNT_W    (CNT_W),
      .PRESCALE (PRESCALE),
      .CNT_RST  (CNT_RST)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .cnt   (cnt_q)
   );

   tcc_capture #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_in    (cap_in),
      .edge_rise (ctl_q.edge_rise),
      .cnt       (cnt_q),
      .stat_rd   (stat_rd),
      .hi_rd     (caph_rd),
      .lo_rd     (capl_rd),
      .cap_val   (cap_val),
      .cap_flag  (cap_flag),
      .cap_lock  (cap_lock)
   );

   tcc_compare #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cnt      (cnt_q),
      .stat_rd  (stat_rd),
      .hi_wr    (cmph_wr),
      .lo_wr    (cmpl_wr),
      .wdata    (bus_wdata),
      .out_lvl  (ctl_q.out_lvl),
      .cmp_val  (cmp_val),
      .cmp_flag (cmp_flag),
      .cmp_pin  (cmp_pin)
   );

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_CTRL: bus_rdata = pack_ctl(ctl_q);
         SEL_STAT: begin
            bus_rdata[STS_CAP] = cap_flag;
            bus_rdata[STS_CMP] = cmp_flag;
         end
         SEL_CAPH: bus_rdata = cap_val[CNT_W-1:DATA_W];
         SEL_CAPL: bus_rdata = cap_val[DATA_W-1:0];
         SEL_CMPH: bus_rdata = cmp_val[CNT_W-1:DATA_W];
         SEL_CMPL: bus_rdata = cmp_val[DATA_W-1:0];
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = (cap_flag & ctl_q.cap_ie) | (cmp_flag & ctl_q.cmp_ie);
endmodule

// File: rtl/tcc_chk.sv
module tcc_chk #(
   parameter int                CNT_W    = 16,
   parameter int                ADDR_W   = 8,
   parameter int                PRESCALE = 4,
   parameter logic [ADDR_W-1:0] OFS_CAPL = 8'h15,
   parameter logic [ADDR_W-1:0] OFS_CMPH = 8'h16,
   parameter logic [ADDR_W-1:0] OFS_CMPL = 8'h17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cap_val,
   input logic              cap_lock,
   input logic              cap_flag,
   input logic              cmp_flag,
   input logic              cmp_pin
);
   logic capl_rd, cmph_wr, cmpl_wr;
   int   gap;
   logic pend_lo;

   assign capl_rd = bus_sel & bus_rd & (bus_addr == OFS_CAPL);
   assign cmph_wr = bus_sel & bus_wr & (bus_addr == OFS_CMPH);
   assign cmpl_wr = bus_sel & bus_wr & (bus_addr == OFS_CMPL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  gap <= 0;
      else if (gap == PRESCALE - 1) gap <= 0;
      else                         gap <= gap + 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_lo <= 1'b1;
      else if (cmph_wr) pend_lo <= 1'b1;
      else if (cmpl_wr) pend_lo <= 1'b0;
   end

   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gap == PRESCALE - 1) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gap != PRESCALE - 1) |=> $stable(cnt));

   p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_lock && !capl_rd) |=> $stable(cap_val));

   p_capflag_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag && !capl_rd) |=> cap_flag);

   p_pin_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cmp_pin));

   p_no_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_lo |=> !$rose(cmp_flag));

   p_cmpflag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag && !cmpl_wr) |=> cmp_flag);
endmodule

bind ctr16_capcmp tcc_chk #(
   .CNT_W    (CNT_W),
   .ADDR_W   (ADDR_W),
   .PRESCALE (PRESCALE),
   .OFS_CAPL (OFS_CAPL),
   .OFS_CMPH (OFS_CMPH),
   .OFS_CMPL (OFS_CMPL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .tick     (tick),
   .cnt      (cnt_q),
   .cap_val  (cap_val),
   .cap_lock (cap_lock),
   .cap_flag (cap_flag),
   .cmp_flag (cmp_flag),
   .cmp_pin  (cmp_pin)
);

// File: tb/sim_ctr16_capcmp.sv
module sim_ctr16_capcmp;
   localparam logic [7:0] A_CTRL = 8'h12;
   localparam logic [7:0] A_STAT = 8'h13;
   localparam logic [7:0] A_CAPH = 8'h14;
   localparam logic [7:0] A_CAPL = 8'h15;
   localparam logic [7:0] A_CMPH = 8'h16;
   localparam logic [7:0] A_CMPL = 8'h17;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cap_in = 1'b0;
   logic       cmp_pin, irq;

   int checks = 0;
   int fails  = 0;
   int k;
   bit done = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t q[$];

   always #2 clk = ~clk;

   ctr16_capcmp u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cap_in    (cap_in),
      .cmp_pin   (cmp_pin),
      .irq       (irq)
   );

   // edges since reset release
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) k <= 0;
      else        k <= k + 1;
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every read strobe
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (bus_sel && bus_rd) begin
            if (q.size() == 0) begin
               chk("scoreboard-empty", bus_rdata, 8'hxx);
            end else begin
               item_t it;
               it = q.pop_front();
               chk(it.tag, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      item_t it;
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
      it.exp = e; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_k(input int kv);
      while (k < kv) @(negedge clk);
      #1;
   endtask

   function automatic logic [15:0] cap_expect(input int kk);
      return 16'hFFFC + 16'((kk + 2) / 4);
   endfunction

   function automatic logic [15:0] now_cnt();
      return 16'hFFFC + 16'(k / 4);
   endfunction

   function automatic int match_edge(input logic [15:0] t);
      logic [15:0] d;
      d = t + 16'd1 - 16'hFFFC;
      return 4 * int'(d);
   endfunction

   task automatic drive_cap(input logic v, output logic [15:0] e);
      @(negedge clk);
      cap_in = v;
      e = cap_expect(k);
   endtask

   initial begin
      #(4 * 60000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] e1, e2, dummy, t, t2, t3;
      int kt;
      idle(3);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 cmp_pin", {7'd0, cmp_pin}, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      rd(A_CTRL, 8'h00, "R1 ctrl");
      rd(A_STAT, 8'h00, "R1 stat");

      // R3: falling edge selected, rising edge ignored
      drive_cap(1'b1, dummy);
      idle(6);
      rd(A_STAT, 8'h00, "R3 wrong edge ignored");
      wait_k(14);
      drive_cap(1'b0, e1);  // R2 value crosses the wrap
      idle(6);
      chk("R9 irq masked", {7'd0, irq}, 8'h00);
      rd(A_CAPH, e1[15:8], "R2 R3 capture hi");
      rd(A_CAPL, e1[7:0],  "R2 R3 capture lo");
      // counter passed 0x0000 against the reset compare value: no match (R7)
      rd(A_STAT, 8'h80, "R5 flag kept without status read; R7 no match before low write");
      rd(A_CAPL, e1[7:0], "R5 low read after status");
      rd(A_STAT, 8'h00, "R5 flag cleared");

      // R4 lock
      wr(A_CTRL, 8'h82);
      rd(A_CAPH, e1[15:8], "R4 hi read");
      drive_cap(1'b1, dummy);
      idle(6);
      rd(A_STAT, 8'h00, "R4 no capture while locked");
      chk("R4 irq", {7'd0, irq}, 8'h00);
      rd(A_CAPL, e1[7:0], "R4 old low byte");
      drive_cap(1'b0, dummy);
      idle(3);
      drive_cap(1'b1, e2);
      idle(6);
      chk("R9 irq capture", {7'd0, irq}, 8'h01);
      rd(A_STAT, 8'h80, "R3 rising capture flag");
      rd(A_CAPH, e2[15:8], "R3 rising capture hi");
      rd(A_CAPL, e2[7:0],  "R3 rising capture lo");
      rd(A_STAT, 8'h00, "R5 cleared again");
      chk("R9 irq cleared", {7'd0, irq}, 8'h00);

      // R6 compare match on tick
      wr(A_CTRL, 8'h41);
      t = now_cnt() + 16'd4;
      wr(A_CMPH, t[15:8]);
      wr(A_CMPL, t[7:0]);
      kt = match_edge(t);
      wait_k(kt - 1);
      chk("R6 pin before tick", {7'd0, cmp_pin}, 8'h00);
      wait_k(kt);
      chk("R6 pin after match", {7'd0, cmp_pin}, 8'h01);
      chk("R9 irq compare", {7'd0, irq}, 8'h01);
      rd(A_STAT, 8'h40, "R6 compare flag");

      // R8 clear
      wr(A_CMPL, t[7:0]);
      rd(A_STAT, 8'h00, "R8 compare flag cleared");
      chk("R8 irq", {7'd0, irq}, 8'h00);

      // R7 high write blocks until low write
      wr(A_CTRL, 8'h40);
      t2 = now_cnt() + 16'd4;
      wr(A_CMPH, t2[15:8]);
      wait_k(match_edge(t2) + 4);
      chk("R7 pin unchanged", {7'd0, cmp_pin}, 8'h01);
      rd(A_STAT, 8'h00, "R7 no match while blocked");
      t3 = now_cnt() + 16'd4;
      wr(A_CMPL, t3[7:0]);
      kt = match_edge({t2[15:8], t3[7:0]});
      wait_k(kt - 1);
      chk("R7 pin before rearmed match", {7'd0, cmp_pin}, 8'h01);
      wait_k(kt);
      chk("R6 low level copied", {7'd0, cmp_pin}, 8'h00);
      rd(A_STAT, 8'h40, "R6 flag again");

      // R10 unused bits
      wr(A_CTRL, 8'hFF);
      rd(A_CTRL, 8'hC3, "R10 ctrl unused bits");
      chk("R9 irq enabled", {7'd0, irq}, 8'h01);

      idle(3);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule